// File: doc/BRIEF.md
# Multi-View Pixel Memory Aperture

This block sits between a host bus and a pixel store and presents that one store through three aliased address windows. Each stored pixel holds 26 meaningful bits. The low 24 bits are three 8-bit colour components, with red in bits 7:0, green in 15:8 and blue in 23:16. Bits 25:24 are two control bits that choose the pixel's display mode. The full window shows all 26 bits. The colour window hides the control bits. The byte window packs the red component of four neighbouring pixels into each host word.

The host drives a request strobe with address, write data and byte strobes, and holds them until a one-cycle ready pulse. Every write is a read-modify-write of the stored words, so the write enables of each window can protect the bits that window does not expose. Storage is four single-port banks interleaved on the low two pixel-index bits, so one row fetch returns the four pixels behind a byte-window word. A small decoder turns the control bits of the pixel touched by each read into a display mode, and it raises a sticky error flag when it sees the reserved code.

Top module: `pix_aperture`

## Requirements
- R1: Full window (addr[15:14]=00, pixel = addr[9:2]): a read returns the stored 26 bits with bits 31:26 zero. A write updates byte lanes 0..2 where strobed, and sets control bits 25:24 from wdata[25:24] when lane 3 is strobed. wdata[31:26] is dropped.
- R2: Colour window (addr[15:14]=01, pixel = addr[9:2]): a read returns stored bits 23:0 with bits 31:24 zero.
- R3: A colour-window write updates only the strobed lanes 0..2. Lane 3 is ignored and the control bits stay as they were.
- R4: Byte window (addr[15:14]=10, word w = addr[7:2]): a read returns in byte lane n the red component (stored bits 7:0) of pixel 4w+n.
- R5: A byte-window write with lane n strobed replaces bits 7:0 of pixel 4w+n only. The other 18 bits of that pixel and all pixels of unstrobed lanes keep their values.
- R6: addr[15:14]=11 is reserved. A read returns zero and reports mode 0, and a write changes no stored bit.
- R7: With req sampled high at a clock edge, ready rises after the 2nd edge for a read and after the 3rd edge for a write. Ready stays high for exactly one cycle.
- R8: With each read response, pix_mode gives the addressed pixel's mode (pixel 4w in the byte window): control 00 gives 0 (indexed 8-bit), 01 gives 1 (24-bit through colormap), and 11 gives 2 (24-bit direct). Writes leave pix_mode unchanged.
- R9: Control code 10 on a read pixel gives pix_mode 0 and sets mode_err. mode_err stays set until reset.
- R10: After reset, ready, rdata, pix_mode and mode_err are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Byte address; bits 15:14 select the window |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte strobes for writes |
| rdata | output | 32 | Read data, valid while ready is high |
| ready | output | 1 | One-cycle completion pulse |
| pix_mode | output | 2 | Decoded mode of the last pixel read |
| mode_err | output | 1 | Sticky flag: reserved control code seen |

## Verification
The same pixels are written with full words, and then with single-lane strobes, through each window in turn. Reading them back through the full window shows whether a window leaked into bits it must protect: the control bits for the colour window, and bits 25:8 or neighbouring pixels for the byte window. The fill gives each pixel a different control code, so reads through all three views tell apart the three valid mode codes and the lane-to-pixel order of the byte view. Reserved-window accesses and a pixel carrying code 10 check that nothing is written and that the error flag latches. The cycle count of every response separates read timing from read-modify-write timing.

// File: rtl/fb_ap_pkg.sv
// Package: shared widths, window codes, mode codes and controller states
// for the multi-view pixel aperture.
package fb_ap_pkg;
    localparam int WORD_W  = 32;   // host word width
    localparam int STORE_W = 26;   // significant bits per stored pixel
    localparam int CTRL_LO = 24;   // lowest control bit position
    localparam int LANES   = 4;    // byte lanes per host word, also bank count

    typedef enum logic [1:0] {
        WIN_FULL  = 2'b00,
        WIN_COLOR = 2'b01,
        WIN_BYTE  = 2'b10,
        WIN_RSVD  = 2'b11
    } win_e;

    typedef enum logic [1:0] {
        PM_INDEX8   = 2'd0,
        PM_MAP24    = 2'd1,
        PM_DIRECT24 = 2'd2
    } pix_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_MERGE,
        ST_RESP
    } ap_state_e;
endpackage

// File: rtl/fb_ap_addr_dec.sv
// Module: fb_ap_addr_dec
// Splits a host byte address into window, bank row and bank index.
// Assumes HA_W-3 >= ROW_W+4. The address bits between the window field
// and the pixel field are ignored, so the windows alias within their range.
module fb_ap_addr_dec
    import fb_ap_pkg::*;
#(
    parameter int HA_W  = 16,
    parameter int ROW_W = 6
) (
    input  logic [HA_W-1:0]  addr,
    output win_e             win,
    output logic [ROW_W-1:0] row,
    output logic [1:0]       bank
);
    logic unused_addr_bits;

    // Window from the top two bits; row position depends on lane packing.
    always_comb begin
        win  = win_e'(addr[HA_W-1:HA_W-2]);
        bank = addr[3:2];
        if (win == WIN_BYTE) row = addr[ROW_W+1:2];
        else                 row = addr[ROW_W+3:4];
    end

    assign unused_addr_bits = ^{addr[HA_W-3:ROW_W+4], addr[1:0]};
endmodule

// File: rtl/fb_ap_bank.sv
// Module: fb_ap_bank
// One single-port pixel bank with a registered read port. Contents are not
// reset. The read register keeps its value on cycles without a read.
module fb_ap_bank #(
    parameter int ROW_W = 6,
    parameter int DW    = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             we,
    input  logic [ROW_W-1:0] row,
    input  logic [DW-1:0]    wd,
    output logic [DW-1:0]    rd
);
    localparam int DEPTH = 1 << ROW_W;
    logic [DW-1:0] mem [DEPTH];

    // Storage write.
    always_ff @(posedge clk) begin
        if (en && we) mem[row] <= wd;
    end

    // Registered read, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          rd <= '0;
        else if (en && !we)  rd <= mem[row];
    end
endmodule

// File: rtl/fb_ap_merge.sv
// Module: fb_ap_merge
// Combinational lane logic. It formats read data for the active window and
// builds the write-back words and bank enables from the fetched row.
// Assumes that fetched holds the row of the current access.
module fb_ap_merge
    import fb_ap_pkg::*;
(
    input  win_e                              win,
    input  logic [1:0]                        bank,
    input  logic [LANES-1:0]                  be,
    input  logic [WORD_W-1:0]                 wdata,
    input  logic [LANES-1:0][STORE_W-1:0]     fetched,
    output logic [WORD_W-1:0]                 rd_fmt,
    output logic [LANES-1:0][STORE_W-1:0]     wr_word,
    output logic [LANES-1:0]                  wr_en
);
    logic [STORE_W-1:0] sel;
    logic [STORE_W-1:0] upd;

    // Merge of the colour lanes, plus control bits for the full window.
    always_comb begin
        sel = fetched[bank];
        upd = sel;
        for (int k = 0; k < 3; k++) begin
            if (be[k]) upd[8*k +: 8] = wdata[8*k +: 8];
        end
        if (win == WIN_FULL && be[3])
            upd[STORE_W-1:CTRL_LO] = wdata[STORE_W-1:CTRL_LO];
    end

    // Per-window read formatting and write-back selection.
    always_comb begin
        rd_fmt  = '0;
        wr_word = fetched;
        wr_en   = '0;
        case (win)
            WIN_FULL: begin
                rd_fmt        = {{(WORD_W-STORE_W){1'b0}}, sel};
                wr_word[bank] = upd;
                wr_en[bank]   = 1'b1;
            end
            WIN_COLOR: begin
                rd_fmt        = {8'h00, sel[CTRL_LO-1:0]};
                wr_word[bank] = upd;
                wr_en[bank]   = 1'b1;
            end
            WIN_BYTE: begin
                for (int n = 0; n < LANES; n++) begin
                    rd_fmt[8*n +: 8] = fetched[n][7:0];
                    if (be[n]) wr_word[n][7:0] = wdata[8*n +: 8];
                end
                wr_en = be;
            end
            default: begin
                rd_fmt = '0;
                wr_en  = '0;
            end
        endcase
    end
endmodule

// File: rtl/fb_ap_mode_dec.sv
// Module: fb_ap_mode_dec
// Decodes a pixel's two control bits into a display mode when upd is high.
// Holds the result between updates. The reserved code decodes as indexed
// 8-bit and sets a sticky error flag that only reset clears.
module fb_ap_mode_dec
    import fb_ap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic [1:0] ctrl,
    output pix_mode_e  mode,
    output logic       err
);
    // Mode register and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= PM_INDEX8;
            err  <= 1'b0;
        end else if (upd) begin
            case (ctrl)
                2'b01:   mode <= PM_MAP24;
                2'b11:   mode <= PM_DIRECT24;
                default: mode <= PM_INDEX8;
            endcase
            if (ctrl == 2'b10) err <= 1'b1;
        end
    end

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    assert_rsvd_code_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ctrl == 2'b10) |=> (err && mode == PM_INDEX8));
    assert_direct_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ctrl == 2'b11) |=> (mode == PM_DIRECT24));
endmodule

// File: rtl/pix_aperture.sv
// Module: pix_aperture (top)
// Host-facing controller that shows one banked pixel store through the
// full, colour and byte windows. Reads take fetch then respond. Writes take
// fetch, merge and write-back, then respond. Assumes the host holds req and
// its fields stable until ready, and drops req in the ready cycle.
module pix_aperture
    import fb_ap_pkg::*;
#(
    parameter int HA_W   = 16,
    parameter int PIXELS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [HA_W-1:0]   addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be,
    output logic [31:0]       rdata,
    output logic              ready,
    output logic [1:0]        pix_mode,
    output logic              mode_err
);
    localparam int ROWS  = PIXELS / LANES;
    localparam int ROW_W = $clog2(ROWS);

    ap_state_e                      state;
    win_e                           dec_win, win_q;
    logic [ROW_W-1:0]               dec_row, row_q, bank_row;
    logic [1:0]                     dec_bank, bank_q, mode_bank;
    logic                           we_q;
    logic [3:0]                     be_q;
    logic [31:0]                    wdata_q;
    logic [LANES-1:0][STORE_W-1:0]  ram_q;
    logic [LANES-1:0][STORE_W-1:0]  wr_word;
    logic [LANES-1:0]               wr_en, bank_en;
    logic [31:0]                    rd_fmt;
    logic                           bank_we, mode_upd;
    logic [1:0]                     mode_ctrl;
    pix_mode_e                      mode_out;

    fb_ap_addr_dec #(.HA_W(HA_W), .ROW_W(ROW_W)) u_dec (
        .addr(addr), .win(dec_win), .row(dec_row), .bank(dec_bank)
    );

    // Controller sequence and latching of the request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            win_q   <= WIN_FULL;
            row_q   <= '0;
            bank_q  <= '0;
            we_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req) begin
                    win_q   <= dec_win;
                    row_q   <= dec_row;
                    bank_q  <= dec_bank;
                    we_q    <= we;
                    be_q    <= be;
                    wdata_q <= wdata;
                    state   <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (we_q) state <= ST_MERGE;
                    else begin
                        rdata <= rd_fmt;
                        state <= ST_RESP;
                    end
                end
                ST_MERGE: state <= ST_RESP;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Bank controls: fetch the whole row on accept, write back in merge.
    always_comb begin
        bank_we  = (state == ST_MERGE);
        bank_row = (state == ST_IDLE) ? dec_row : row_q;
        for (int g = 0; g < LANES; g++)
            bank_en[g] = (state == ST_IDLE && req) || (bank_we && wr_en[g]);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        fb_ap_bank #(.ROW_W(ROW_W), .DW(STORE_W)) u_bank (
            .clk(clk), .rst_n(rst_n), .en(bank_en[g]), .we(bank_we),
            .row(bank_row), .wd(wr_word[g]), .rd(ram_q[g])
        );
        assert_byte_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_MERGE && win_q == WIN_BYTE)
            |-> (wr_word[g][STORE_W-1:8] == ram_q[g][STORE_W-1:8]));
    end

    fb_ap_merge u_merge (
        .win(win_q), .bank(bank_q), .be(be_q), .wdata(wdata_q),
        .fetched(ram_q), .rd_fmt(rd_fmt), .wr_word(wr_word), .wr_en(wr_en)
    );

    // Mode source: the addressed pixel, or pixel 4w in the byte window.
    always_comb begin
        mode_bank = (win_q == WIN_BYTE) ? 2'd0 : bank_q;
        mode_upd  = (state == ST_FETCH) && !we_q;
        mode_ctrl = (win_q == WIN_RSVD) ? 2'b00
                  : ram_q[mode_bank][STORE_W-1:CTRL_LO];
    end

    fb_ap_mode_dec u_mode (
        .clk(clk), .rst_n(rst_n), .upd(mode_upd), .ctrl(mode_ctrl),
        .mode(mode_out), .err(mode_err)
    );

    assign pix_mode = mode_out;
    assign ready    = (state == ST_RESP);

    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    assert_color_ctrl_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MERGE && win_q == WIN_COLOR)
        |-> (wr_word[bank_q][STORE_W-1:CTRL_LO] == ram_q[bank_q][STORE_W-1:CTRL_LO]));
    assert_rsvd_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MERGE && win_q == WIN_RSVD) |-> (bank_en == '0));
    assert_color_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !we_q && win_q == WIN_COLOR) |-> (rdata[31:24] == 8'h00));
    assert_full_top_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !we_q && win_q == WIN_FULL) |-> (rdata[31:26] == 6'h00));
endmodule

// File: tb/pix_aperture_bench.sv
// Scoreboard bench. The access task computes expected results from its own
// pixel model and queues them. The monitor pops one item per ready pulse.
module pix_aperture_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic        ready;
    logic [1:0]  pix_mode;
    logic        mode_err;

    int n_tests = 0, n_fail = 0, cyc = 0;
    logic [25:0] model [256];
    logic exp_err = 1'b0;
    logic prev_ready = 1'b0;

    typedef struct {
        logic        rd;
        logic [31:0] data;
        logic [1:0]  mode;
        logic        err;
        int          lat;
        int          start;
        string       rq;
    } item_t;
    item_t sb[$];

    pix_aperture u_pix_aperture (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .be(be), .rdata(rdata), .ready(ready),
        .pix_mode(pix_mode), .mode_err(mode_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [1:0] mode_of(input logic [1:0] c);
        if (c == 2'b01) return 2'd1;
        if (c == 2'b11) return 2'd2;
        return 2'd0;
    endfunction

    // win: 0 full, 1 colour, 2 byte, 3 reserved; idx is pixel or byte-window word
    task automatic access(input logic wr, input logic [1:0] win, input int idx,
                          input logic [31:0] wd, input logic [3:0] bstr,
                          input string rq);
        item_t it;
        int p;
        p = (win == 2'd2) ? 4*idx : idx;
        it.rd = !wr;
        it.rq = rq;
        it.lat = wr ? 3 : 2;
        it.mode = 2'd0;
        it.err = exp_err;
        it.data = '0;
        if (!wr) begin
            case (win)
                2'd0: it.data = {6'b0, model[p]};
                2'd1: it.data = {8'b0, model[p][23:0]};
                2'd2: for (int n = 0; n < 4; n++) it.data[8*n +: 8] = model[p+n][7:0];
                default: it.data = '0;
            endcase
            if (win != 2'd3) begin
                it.mode = mode_of(model[p][25:24]);
                if (model[p][25:24] == 2'b10) exp_err = 1'b1;
            end
            it.err = exp_err;
        end else begin
            case (win)
                2'd0, 2'd1: begin
                    for (int k = 0; k < 3; k++)
                        if (bstr[k]) model[p][8*k +: 8] = wd[8*k +: 8];
                    if (win == 2'd0 && bstr[3]) model[p][25:24] = wd[25:24];
                end
                2'd2: for (int n = 0; n < 4; n++)
                    if (bstr[n]) model[p+n][7:0] = wd[8*n +: 8];
                default: ;
            endcase
        end
        @(negedge clk);
        req = 1'b1; we = wr; wdata = wd; be = bstr;
        addr = (win == 2'd2) ? {win, 6'b0, idx[5:0], 2'b00}
                             : {win, 4'b0, idx[7:0], 2'b00};
        it.start = cyc;
        sb.push_back(it);
        do @(negedge clk); while (ready !== 1'b1);
        req = 1'b0;
    endtask

    // Monitor: compares each response and the one-cycle ready pulse (R7).
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ready && ready) chk("R7", "ready pulse width", 32'd1, 32'd0);
            if (ready) begin
                if (sb.size() == 0) chk("R7", "unexpected ready", 32'd1, 32'd0);
                else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(it.rq, "latency", cyc - it.start, it.lat);
                    if (it.rd) begin
                        chk(it.rq, "rdata", rdata, it.data);
                        chk({it.rq, "/R8"}, "pix_mode", {30'b0, pix_mode}, {30'b0, it.mode});
                        chk({it.rq, "/R9"}, "mode_err", {31'b0, mode_err}, {31'b0, it.err});
                    end
                end
            end
            prev_ready = ready;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] ctl [8];
        ctl = '{2'b00, 2'b01, 2'b11, 2'b01, 2'b00, 2'b11, 2'b01, 2'b00};
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10", "ready", {31'b0, ready}, 32'd0);
        chk("R10", "rdata", rdata, 32'd0);
        chk("R10", "pix_mode", {30'b0, pix_mode}, 32'd0);
        chk("R10", "mode_err", {31'b0, mode_err}, 32'd0);
        rst_n = 1'b1;
        // R1 fill through the full window, junk in bits 31:26
        for (int i = 0; i < 16; i++)
            access(1'b1, 2'd0, i, 32'hFC00_0000 | ({30'b0, ctl[i%8]} << 24)
                   | (i * 32'h0001_0203 + 32'h0010_2030), 4'hF, "R1");
        for (int i = 0; i < 8; i++) access(1'b0, 2'd0, i, '0, 4'h0, "R1");
        // R1 partial strobes
        access(1'b1, 2'd0, 2, 32'hFFAA_5500, 4'b0100, "R1");
        access(1'b1, 2'd0, 4, 32'hFF00_0000, 4'b1000, "R1");
        access(1'b0, 2'd0, 2, '0, 4'h0, "R1");
        access(1'b0, 2'd0, 4, '0, 4'h0, "R1");
        // R2 colour reads
        for (int i = 0; i < 4; i++) access(1'b0, 2'd1, i, '0, 4'h0, "R2");
        // R3 colour writes cannot reach the control bits
        access(1'b1, 2'd1, 1, 32'hFE12_3456, 4'hF, "R3");
        access(1'b1, 2'd1, 5, 32'h0000_7700, 4'b0010, "R3");
        access(1'b0, 2'd0, 1, '0, 4'h0, "R3");
        access(1'b0, 2'd0, 5, '0, 4'h0, "R3");
        // R4 byte reads
        access(1'b0, 2'd2, 0, '0, 4'h0, "R4");
        access(1'b0, 2'd2, 1, '0, 4'h0, "R4");
        // R5 byte writes on lanes 0 and 2 only
        access(1'b1, 2'd2, 0, 32'h1122_3344, 4'b0101, "R5");
        for (int i = 0; i < 4; i++) access(1'b0, 2'd0, i, '0, 4'h0, "R5");
        access(1'b0, 2'd2, 0, '0, 4'h0, "R5");
        // R6 reserved window
        access(1'b0, 2'd3, 0, '0, 4'h0, "R6");
        access(1'b1, 2'd3, 0, 32'hFFFF_FFFF, 4'hF, "R6");
        access(1'b0, 2'd0, 0, '0, 4'h0, "R6");
        // R9 reserved control code sets the sticky flag
        access(1'b1, 2'd0, 9, 32'h020A_0B0C, 4'hF, "R9");
        access(1'b0, 2'd0, 9, '0, 4'h0, "R9");
        access(1'b0, 2'd0, 1, '0, 4'h0, "R9");
        access(1'b0, 2'd1, 5, '0, 4'h0, "R8");
        repeat (3) @(negedge clk);
        chk("R7", "scoreboard drained", sb.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule